// File: doc/BRIEF.md
# Burst Request Scheduler with Write Draining

This block sits in front of a single DRAM channel and decides which queued burst goes to the channel next. Reads and writes arrive on separate valid/ready inputs. Each request is aligned to a burst boundary and held in its own queue, a read queue or a write queue. The rank, bank and row of each entry come from fixed fields of the aligned address. A downstream command stage receives the chosen entry on an issue port and pops it with `issue_ready`. It also supplies, per bank, whether a row is open and which row it is, and per rank whether a refresh is in progress.

The block serves one direction at a time. It stays on reads until the write queue grows past a high watermark, or until no read is waiting. Once on writes, it keeps issuing writes until a minimum number of writes has been sent for that turn and the write queue has fallen to a low watermark. It also turns back when the write queue empties. Within the active queue, the block first prefers an entry that hits the open row of its bank. Next it prefers an entry on the rank of the previous burst, except on the first burst after a turnaround. Remaining ties go to the oldest entry. Entries on a rank under refresh are skipped.

A read that matches a queued write is answered from the write queue and never enters the read queue. A write to a burst that is already queued is absorbed into the existing entry.

Top module: `burst_sched`

## Requirements
- R1: While serving reads, if the write queue holds more than WR_HI (default 5) entries, the next cycle serves writes (`issue_write` = 1).
- R2: After turning to writes, the block keeps serving writes until at least MIN_WR (default 5) writes have been issued in that turn and the write count is at most WR_LO (default 2) with a read waiting; then it returns to reads.
- R3: A read whose burst address (address with the low 6 bits cleared) equals a queued write is accepted, raises `fwd_valid` for one cycle, one cycle later, with `fwd_addr` set to the aligned address, and is never issued.
- R4: A write whose burst address equals a queued write adds no entry, so the burst is issued only once.
- R5: An entry whose bank (index = {rank bit 8, bank bits 7:6}) is open on the entry's row (bits 16:9) is issued before older entries that do not hit.
- R6: Among entries of equal preference, the oldest is issued first.
- R7: An entry whose rank has `rank_busy` set is not issued while that bit is set.
- R8: Except for the first burst after a turnaround, an entry on the rank of the previous burst is preferred over an older entry on another rank.
- R9: `rd_ready` (resp. `wr_ready`) is low while its queue holds 8 entries.
- R10: After reset both ready outputs are high and `issue_valid` and `fwd_valid` are low.
- R11: While serving reads with no read queued and at least one write queued, the block turns to writes. While serving writes with the write queue empty, it returns to reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | Read request present |
| rd_addr | input | 32 | Read byte address |
| rd_ready | output | 1 | Read queue can accept |
| wr_valid | input | 1 | Write request present |
| wr_addr | input | 32 | Write byte address |
| wr_ready | output | 1 | Write queue can accept |
| bank_open | input | 8 | Per bank: a row is open |
| bank_row | input | 64 | Per bank: open row number, 8 bits each |
| rank_busy | input | 2 | Per rank: refresh in progress |
| issue_valid | output | 1 | A chosen entry is offered |
| issue_write | output | 1 | Offered entry is a write |
| issue_addr | output | 32 | Burst-aligned address of offered entry |
| issue_ready | input | 1 | Downstream takes the offered entry |
| fwd_valid | output | 1 | A read was served from the write queue |
| fwd_addr | output | 32 | Burst address of the forwarded read |

## Verification
The hardest state to reach is the end of a write turn where the occupancy test and the minimum-writes test disagree. Reaching it needs the write queue filled past the high watermark while reads are kept waiting. The bench does this with issue held off: it queues two reads, then six writes, and pops writes one at a time. After the fourth pop the count already meets the low watermark, but the turn must go on until the fifth. Forwarding and merging are checked by exact burst collisions at non-aligned offsets. A burst absorbed or forwarded this way must never appear on the issue port.

// File: rtl/burst_sched_pkg.sv
// Shared types for the burst scheduler.
package burst_sched_pkg;
    // Direction currently served on the data bus.
    typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;
endpackage

// File: rtl/sched_queue.sv
// Compacting request queue: entry 0 is the oldest. Any entry may be removed;
// younger entries shift down. Assumes push is only asserted when not full
// (or when an entry leaves in the same cycle).
module sched_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [AW-1:0]             push_addr,
    input  logic                      pop,
    input  logic [IW-1:0]             pop_idx,
    output logic [DEPTH-1:0][AW-1:0]  ent_addr,
    output logic [DEPTH-1:0]          ent_valid,
    output logic [CW-1:0]             count
);
    logic [DEPTH-1:0][AW-1:0] nxt_addr;
    logic [CW-1:0]            wpos;

    // Next contents: remove the popped entry, then append at the tail.
    always_comb begin
        nxt_addr = ent_addr;
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (pop && IW'(i) >= pop_idx) nxt_addr[i] = ent_addr[i+1];
        end
        if (pop && IW'(DEPTH - 1) >= pop_idx) nxt_addr[DEPTH-1] = '0;
        wpos = count - CW'(pop);
        if (push) nxt_addr[wpos[IW-1:0]] = push_addr;
    end

    // Entry and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_addr <= '0;
            count    <= '0;
        end else begin
            ent_addr <= nxt_addr;
            count    <= count + CW'(push) - CW'(pop);
        end
    end

    // Valid flags follow occupancy.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) ent_valid[i] = (CW'(i) < count);
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count < CW'(DEPTH)));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> ent_valid[pop_idx]);
endmodule

// File: rtl/sched_pick.sv
// Combinational selector over one queue. Skips entries whose rank is under
// refresh; prefers open-row hits (when HIT_FIRST), then the last rank
// (when use_rank), then age. Assumes entry 0 is oldest.
module sched_pick #(
    parameter int DEPTH     = 8,
    parameter int AW        = 32,
    parameter int BOFF      = 6,
    parameter int BANK_W    = 2,
    parameter int RANK_W    = 1,
    parameter int ROW_W     = 8,
    parameter bit HIT_FIRST = 1'b1,
    localparam int NB       = 1 << (BANK_W + RANK_W),
    localparam int NR       = 1 << RANK_W,
    localparam int IW       = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [DEPTH-1:0]         ent_valid,
    input  logic [NB-1:0]            bank_open,
    input  logic [NB*ROW_W-1:0]      bank_row,
    input  logic [NR-1:0]            rank_busy,
    input  logic [RANK_W-1:0]        last_rank,
    input  logic                     use_rank,
    output logic                     found,
    output logic [IW-1:0]            idx
);
    // Scan oldest to youngest, keeping the first entry with the highest key.
    always_comb begin
        logic [1:0]                  best;
        logic [1:0]                  key;
        logic [RANK_W-1:0]           rk;
        logic [BANK_W+RANK_W-1:0]    bk;
        logic [ROW_W-1:0]            rw;
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            rk  = ent_addr[i][BOFF+BANK_W +: RANK_W];
            bk  = ent_addr[i][BOFF +: BANK_W+RANK_W];
            rw  = ent_addr[i][BOFF+BANK_W+RANK_W +: ROW_W];
            key = {HIT_FIRST && bank_open[bk] && (bank_row[bk*ROW_W +: ROW_W] == rw),
                   use_rank && (rk == last_rank)};
            if (ent_valid[i] && !rank_busy[rk] && (!found || key > best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = key;
            end
        end
    end
endmodule

// File: rtl/burst_sched.sv
// Read/write burst scheduler for one DRAM channel. Holds a read and a write
// queue of burst-aligned addresses, forwards reads that hit queued writes,
// merges duplicate writes, and turns the bus direction on write watermarks.
// Assumes the downstream stage honours bank timing; this block only orders.
module burst_sched
    import burst_sched_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BOFF      = 6,
    parameter int BANK_W    = 2,
    parameter int RANK_W    = 1,
    parameter int ROW_W     = 8,
    parameter int RQ_DEPTH  = 8,
    parameter int WQ_DEPTH  = 8,
    parameter int WR_HI     = 5,
    parameter int WR_LO     = 2,
    parameter int MIN_WR    = 5,
    parameter bit HIT_FIRST = 1'b1,
    localparam int NB       = 1 << (BANK_W + RANK_W),
    localparam int NR       = 1 << RANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_valid,
    input  logic [AW-1:0]        rd_addr,
    output logic                 rd_ready,
    input  logic                 wr_valid,
    input  logic [AW-1:0]        wr_addr,
    output logic                 wr_ready,
    input  logic [NB-1:0]        bank_open,
    input  logic [NB*ROW_W-1:0]  bank_row,
    input  logic [NR-1:0]        rank_busy,
    output logic                 issue_valid,
    output logic                 issue_write,
    output logic [AW-1:0]        issue_addr,
    input  logic                 issue_ready,
    output logic                 fwd_valid,
    output logic [AW-1:0]        fwd_addr
);
    localparam int RCW = $clog2(RQ_DEPTH + 1);
    localparam int WCW = $clog2(WQ_DEPTH + 1);
    localparam int RIW = $clog2(RQ_DEPTH);
    localparam int WIW = $clog2(WQ_DEPTH);
    localparam int DW  = $clog2(MIN_WR + 1);
    localparam logic [AW-1:0] ALIGN = ~((AW'(1) << BOFF) - AW'(1));

    dir_e                          dir;
    logic                          fresh;
    logic [RANK_W-1:0]             last_rank;
    logic [DW-1:0]                 wr_done;
    logic [RQ_DEPTH-1:0][AW-1:0]   rq_addr;
    logic [WQ_DEPTH-1:0][AW-1:0]   wq_addr;
    logic [RQ_DEPTH-1:0]           rq_valid;
    logic [WQ_DEPTH-1:0]           wq_valid;
    logic [RCW-1:0]                rq_count;
    logic [WCW-1:0]                wq_count;
    logic                          rd_found, wr_found;
    logic [RIW-1:0]                rd_idx;
    logic [WIW-1:0]                wr_idx;
    logic [AW-1:0]                 rd_al, wr_al;
    logic                          rd_hit_wq, wr_merge;
    logic                          rq_push, wq_push, rq_pop, wq_pop;

    assign rd_al    = rd_addr & ALIGN;
    assign wr_al    = wr_addr & ALIGN;
    assign rd_ready = (rq_count != RCW'(RQ_DEPTH));
    assign wr_ready = (wq_count != WCW'(WQ_DEPTH));

    // Address matching against the write queue for forwarding and merging.
    always_comb begin
        rd_hit_wq = 1'b0;
        wr_merge  = 1'b0;
        for (int i = 0; i < WQ_DEPTH; i++) begin
            if (wq_valid[i] && wq_addr[i] == rd_al) rd_hit_wq = 1'b1;
            if (wq_valid[i] && wq_addr[i] == wr_al && !(wq_pop && wr_idx == WIW'(i)))
                wr_merge = 1'b1;
        end
    end

    assign rq_push = rd_valid && rd_ready && !rd_hit_wq;
    assign wq_push = wr_valid && wr_ready && !wr_merge;

    // Offer the entry chosen from the queue of the active direction.
    always_comb begin
        issue_write = (dir == DIR_WR);
        issue_valid = issue_write ? wr_found : rd_found;
        issue_addr  = issue_write ? wq_addr[wr_idx] : rq_addr[rd_idx];
    end

    assign rq_pop = issue_valid && issue_ready && !issue_write;
    assign wq_pop = issue_valid && issue_ready && issue_write;

    sched_queue #(.DEPTH(RQ_DEPTH), .AW(AW)) u_rq (
        .clk(clk), .rst_n(rst_n), .push(rq_push), .push_addr(rd_al),
        .pop(rq_pop), .pop_idx(rd_idx), .ent_addr(rq_addr),
        .ent_valid(rq_valid), .count(rq_count));

    sched_queue #(.DEPTH(WQ_DEPTH), .AW(AW)) u_wq (
        .clk(clk), .rst_n(rst_n), .push(wq_push), .push_addr(wr_al),
        .pop(wq_pop), .pop_idx(wr_idx), .ent_addr(wq_addr),
        .ent_valid(wq_valid), .count(wq_count));

    sched_pick #(.DEPTH(RQ_DEPTH), .AW(AW), .BOFF(BOFF), .BANK_W(BANK_W),
                 .RANK_W(RANK_W), .ROW_W(ROW_W), .HIT_FIRST(HIT_FIRST)) u_rpick (
        .ent_addr(rq_addr), .ent_valid(rq_valid), .bank_open(bank_open),
        .bank_row(bank_row), .rank_busy(rank_busy), .last_rank(last_rank),
        .use_rank(!fresh), .found(rd_found), .idx(rd_idx));

    sched_pick #(.DEPTH(WQ_DEPTH), .AW(AW), .BOFF(BOFF), .BANK_W(BANK_W),
                 .RANK_W(RANK_W), .ROW_W(ROW_W), .HIT_FIRST(HIT_FIRST)) u_wpick (
        .ent_addr(wq_addr), .ent_valid(wq_valid), .bank_open(bank_open),
        .bank_row(bank_row), .rank_busy(rank_busy), .last_rank(last_rank),
        .use_rank(!fresh), .found(wr_found), .idx(wr_idx));

    // Direction turnaround on watermarks, plus per-turn write counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir     <= DIR_RD;
            fresh   <= 1'b1;
            wr_done <= '0;
        end else if (dir == DIR_RD &&
                     (wq_count > WCW'(WR_HI) || (rq_count == '0 && wq_count != '0))) begin
            dir     <= DIR_WR;
            fresh   <= 1'b1;
            wr_done <= '0;
        end else if (dir == DIR_WR &&
                     (wq_count == '0 || (wr_done >= DW'(MIN_WR) &&
                      wq_count <= WCW'(WR_LO) && rq_count != '0))) begin
            dir   <= DIR_RD;
            fresh <= 1'b1;
        end else if (issue_valid && issue_ready) begin
            fresh <= 1'b0;
            if (issue_write && wr_done != DW'(MIN_WR)) wr_done <= wr_done + DW'(1);
        end
    end

    // Remember the rank of the last burst sent.
    always_ff @(posedge clk) begin
        if (!rst_n) last_rank <= '0;
        else if (issue_valid && issue_ready) last_rank <= issue_addr[BOFF+BANK_W +: RANK_W];
    end

    // One-cycle notice that a read was answered from the write queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_addr  <= '0;
        end else begin
            fwd_valid <= rd_valid && rd_ready && rd_hit_wq;
            fwd_addr  <= rd_al;
        end
    end

    // R1
    drain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == DIR_RD && wq_count > WCW'(WR_HI)) |=> issue_write);

    // R2
    min_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == DIR_WR && wq_count != '0 && wr_done < DW'(MIN_WR)) |=> issue_write);

    // R3
    fwd_no_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (rq_count <= $past(rq_count)));

    // R7
    busy_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !rank_busy[issue_addr[BOFF+BANK_W +: RANK_W]]);

    // R4: no two write entries share a burst address.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < WQ_DEPTH; i++)
                for (int j = i + 1; j < WQ_DEPTH; j++)
                    wq_unique_chk: assert (!(wq_valid[j] && wq_addr[i] == wq_addr[j]));
        end
    end
endmodule

// File: tb/burst_sched_tb.sv
// Directed bench for burst_sched: one task per scenario.
module burst_sched_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0, wr_valid = 1'b0, issue_ready = 1'b0;
    logic [31:0] rd_addr = '0, wr_addr = '0;
    logic        rd_ready, wr_ready, issue_valid, issue_write, fwd_valid;
    logic [31:0] issue_addr, fwd_addr;
    logic [7:0]  bank_open = '0;
    logic [63:0] bank_row = '0;
    logic [1:0]  rank_busy = '0;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    burst_sched u_dut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_ready(wr_ready), .bank_open(bank_open), .bank_row(bank_row),
        .rank_busy(rank_busy), .issue_valid(issue_valid), .issue_write(issue_write),
        .issue_addr(issue_addr), .issue_ready(issue_ready),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr));

    function automatic logic [31:0] mk(int rk, int bk, int row);
        return 32'((row << 9) | (rk << 8) | (bk << 6));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_rd(logic [31:0] a);
        @(negedge clk); rd_valid = 1'b1; rd_addr = a;
        @(negedge clk); rd_valid = 1'b0;
    endtask

    task automatic push_wr(logic [31:0] a);
        @(negedge clk); wr_valid = 1'b1; wr_addr = a;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    // Check the offered entry, take it, and let the direction logic settle.
    task automatic pop_chk(string req, logic wr, logic [31:0] a);
        chk(req, {30'd0, issue_valid, issue_write}, {30'd0, 1'b1, wr});
        chk(req, issue_addr, a);
        issue_ready = 1'b1;
        @(negedge clk); issue_ready = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 rd_ready", 32'(rd_ready), 32'd1);
        chk("R10 wr_ready", 32'(wr_ready), 32'd1);
        chk("R10 issue_valid", 32'(issue_valid), 32'd0);
        chk("R10 fwd_valid", 32'(fwd_valid), 32'd0);
    endtask

    task automatic t_oldest();
        push_rd(mk(0,0,1)); push_rd(mk(0,1,2)); push_rd(mk(0,2,3));
        pop_chk("R6 first", 1'b0, mk(0,0,1));
        pop_chk("R6 second", 1'b0, mk(0,1,2));
        pop_chk("R6 third", 1'b0, mk(0,2,3));
    endtask

    task automatic t_rowhit();
        bank_open[2] = 1'b1; bank_row[2*8 +: 8] = 8'd7;
        push_rd(mk(0,1,5)); push_rd(mk(0,2,7));
        pop_chk("R5 hit first", 1'b0, mk(0,2,7));
        pop_chk("R5 miss after", 1'b0, mk(0,1,5));
        bank_open = '0;
    endtask

    task automatic t_rank();
        push_rd(mk(1,0,0)); push_rd(mk(0,0,1));
        pop_chk("R8 same rank", 1'b0, mk(0,0,1));
        pop_chk("R8 other rank", 1'b0, mk(1,0,0));
    endtask

    task automatic t_refresh();
        rank_busy[1] = 1'b1;
        push_rd(mk(1,1,4)); push_rd(mk(0,3,4));
        pop_chk("R7 skip busy", 1'b0, mk(0,3,4));
        chk("R7 held", 32'(issue_valid), 32'd0);
        rank_busy = '0;
        @(negedge clk);
        pop_chk("R7 released", 1'b0, mk(1,1,4));
    endtask

    task automatic t_full();
        for (int i = 0; i < 8; i++) push_rd(mk(0,0,40+i));
        chk("R9 full", 32'(rd_ready), 32'd0);
        for (int i = 0; i < 8; i++) pop_chk("R9 drain", 1'b0, mk(0,0,40+i));
        chk("R9 ready again", 32'(rd_ready), 32'd1);
    endtask

    task automatic t_merge();
        push_wr(mk(0,3,9)); push_wr(mk(0,3,9) + 32'd8);
        @(negedge clk);
        chk("R11 to writes", 32'(issue_write), 32'd1);
        pop_chk("R4 one entry", 1'b1, mk(0,3,9));
        chk("R4 merged gone", 32'(issue_valid), 32'd0);
        @(negedge clk);
        chk("R11 back to reads", 32'(issue_write), 32'd0);
    endtask

    task automatic t_forward();
        push_wr(mk(1,2,11));
        push_rd(mk(1,2,11) + 32'd4);
        chk("R3 fwd pulse", 32'(fwd_valid), 32'd1);
        chk("R3 fwd addr", fwd_addr, mk(1,2,11));
        @(negedge clk);
        chk("R3 pulse ends", 32'(fwd_valid), 32'd0);
        pop_chk("R3 write out", 1'b1, mk(1,2,11));
        @(negedge clk);
        chk("R3 read not queued", 32'(issue_valid), 32'd0);
    endtask

    task automatic t_drain();
        push_rd(mk(1,0,20)); push_rd(mk(1,0,21));
        for (int i = 0; i < 5; i++) push_wr(mk(0,1,30+i));
        @(negedge clk);
        chk("R1 at watermark", 32'(issue_write), 32'd0);
        push_wr(mk(0,1,35));
        @(negedge clk);
        chk("R1 above watermark", 32'(issue_write), 32'd1);
        for (int i = 0; i < 4; i++) pop_chk("R2 keep writing", 1'b1, mk(0,1,30+i));
        chk("R2 min not met", 32'(issue_write), 32'd1);
        pop_chk("R2 fifth write", 1'b1, mk(0,1,34));
        chk("R2 return to reads", 32'(issue_write), 32'd0);
        pop_chk("R2 read a", 1'b0, mk(1,0,20));
        pop_chk("R2 read b", 1'b0, mk(1,0,21));
        @(negedge clk);
        pop_chk("R11 leftover write", 1'b1, mk(0,1,35));
        @(negedge clk);
        chk("R11 all empty", 32'(issue_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oldest();
        t_rowhit();
        t_rank();
        t_refresh();
        t_full();
        t_merge();
        t_forward();
        t_drain();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule